// File: doc/BRIEF.md
# Password-Gated Protection Lock Controller

This block guards the flag that decides whether per-sector non-volatile protection bits in a serial memory may be changed. It holds a 64-bit one-time-programmable password and a one-time mode bit. Both are modelled as registers that keep their value through reset. The block accepts one decoded command per cycle, with a 64-bit operand. The commands are: program the password, read the password back, program the mode bit, unlock with a password, set the lock flag, and read status.

Before password mode is selected, the password can be written and read back freely. Writes can only clear bits. In this phase the lock flag is an ordinary register: reset opens it and a set command closes it. Once the mode bit is cleared, the password is sealed and the lock flag comes out of every reset closed. The only way to open the flag is an unlock command whose operand matches the stored password exactly. A correct unlock keeps the busy flag up for a short delay. A wrong unlock keeps it up for a long penalty delay and raises an error flag, which makes guessing the password far too slow to succeed. Both delays are parameters in clock cycles.

Top module: `pwd_lock_ctrl`

## Requirements
- R1: Out of the factory state the password is all ones. Before password mode, a password read (op 2) answers one cycle later with rd_valid_o high and the stored password on rd_data_o.
- R2: Before password mode, a password program (op 1) stores old AND operand, so a bit can only go from 1 to 0.
- R3: A mode program (op 3) with operand bit 2 at 0 selects password mode. A 1 in that bit has no effect, and the mode stays selected through every later reset.
- R4: In password mode, a password read returns all zeros with rd_valid_o high, and a password program leaves the stored password unchanged.
- R5: lock_o (1 = closed) resets to 0 before password mode and to 1 in password mode. A lock-set command (op 5) drives it to 1. prot_wr_en_o is always the inverse of lock_o.
- R6: In password mode, an unlock (op 4) with an exactly matching operand raises wip_o for UNLOCK_CYCLES cycles and clears p_err_o. It opens lock_o in the cycle wip_o falls.
- R7: In password mode, an unlock with any mismatching operand sets p_err_o and holds wip_o for PENALTY_CYCLES cycles, with lock_o unchanged. p_err_o stays set until the next accepted unlock or a reset.
- R8: While wip_o is 1, every command except status read is ignored, unlock included.
- R9: A status read (op 6) is always answered one cycle later with rd_valid_o high and rd_data_o = {62 zeros, p_err_o, wip_o}, taken from the cycle in which the command was given, busy or not.
- R10: Before password mode, an unlock command is ignored: wip_o and p_err_o stay 0 and lock_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (non-volatile state survives it) |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode: 0 none, 1 password program, 2 password read, 3 mode program, 4 unlock, 5 lock set, 6 status read |
| cmd_data_i | input | 64 | Command operand |
| rd_valid_o | output | 1 | Read answer present |
| rd_data_o | output | 64 | Read answer |
| lock_o | output | 1 | Lock flag, 1 = protection bits frozen |
| prot_wr_en_o | output | 1 | Protection-bit changes permitted |
| wip_o | output | 1 | Busy |
| p_err_o | output | 1 | Protection error |

## Verification
The assertions watch, on every cycle, several rules. Busy only starts from an accepted unlock, and an error only appears together with busy. The lock flag only opens as busy falls with no error, and only closes after an accepted lock-set. The mode bit never reverts. A sealed password never reads back, and status answers always mirror the previous cycle. What they cannot show is handled by the bench scenarios. These cover the exact delay lengths, and AND-only programming over a sequence of writes. They also show that a correct password given during a penalty is dropped, and that an unlock made after several resets still matches the password sealed before them.

// File: rtl/pwd_lock_pkg.sv
package pwd_lock_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_PWD_PGM  = 3'd1,
    OP_PWD_RD   = 3'd2,
    OP_MODE_PGM = 3'd3,
    OP_UNLOCK   = 3'd4,
    OP_LOCK_SET = 3'd5,
    OP_STAT_RD  = 3'd6
  } pl_op_e;

  localparam int unsigned MODE_BIT = 2;
endpackage

// File: rtl/pwd_store.sv
module pwd_store #(
  parameter int unsigned PWD_W    = 64,
  parameter int unsigned MODE_BIT = 2
) (
  input  logic             clk_i,
  input  logic             pgm_i,
  input  logic             mode_pgm_i,
  input  logic [PWD_W-1:0] data_i,
  output logic [PWD_W-1:0] pwd_o,
  output logic             pwd_mode_o
);
  // non-volatile: factory value at power-on, untouched by reset
  logic [PWD_W-1:0] pwd_q    = '1;
  logic             mode_n_q = 1'b1;

  always_ff @(posedge clk_i) begin
    if (pgm_i)      pwd_q    <= pwd_q & data_i;
    if (mode_pgm_i) mode_n_q <= mode_n_q & data_i[MODE_BIT];
  end

  assign pwd_o      = pwd_q;
  assign pwd_mode_o = ~mode_n_q;
endmodule

// File: rtl/pwd_match.sv
module pwd_match #(
  parameter int unsigned PWD_W   = 64,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic [PWD_W-1:0] a_i,
  input  logic [PWD_W-1:0] b_i,
  output logic             match_o
);
  localparam int unsigned N_CHUNK = PWD_W / CHUNK_W;

  logic [N_CHUNK-1:0] chunk_eq;

  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign chunk_eq[g] = (a_i[g*CHUNK_W +: CHUNK_W] == b_i[g*CHUNK_W +: CHUNK_W]);
  end

  assign match_o = &chunk_eq;
endmodule

// File: rtl/pwd_delay_timer.sv
module pwd_delay_timer #(
  parameter int unsigned SHORT_CYCLES = 4,
  parameter int unsigned LONG_CYCLES  = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAX_CYC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= long_i ? LONG_LD : SHORT_LD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pwd_lock_ctrl.sv
module pwd_lock_ctrl
  import pwd_lock_pkg::*;
#(
  parameter int unsigned PWD_W          = 64,
  parameter int unsigned CHUNK_W        = 16,
  parameter int unsigned UNLOCK_CYCLES  = 4,
  parameter int unsigned PENALTY_CYCLES = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [PWD_W-1:0] cmd_data_i,
  output logic             rd_valid_o,
  output logic [PWD_W-1:0] rd_data_o,
  output logic             lock_o,
  output logic             prot_wr_en_o,
  output logic             wip_o,
  output logic             p_err_o
);
  pl_op_e           op;
  logic             busy, done, accept, match, pwd_mode;
  logic             pgm_en, mode_en, unlock_go, lock_set, rd_pwd, rd_stat;
  logic [PWD_W-1:0] pwd;
  logic             lock_q, p_err_q, good_q, rd_valid_q;
  logic [PWD_W-1:0] rd_data_q;

  assign op        = pl_op_e'(cmd_op_i);
  assign accept    = cmd_valid_i && !busy;
  assign pgm_en    = accept && (op == OP_PWD_PGM) && !pwd_mode;
  assign mode_en   = accept && (op == OP_MODE_PGM);
  assign unlock_go = accept && (op == OP_UNLOCK) && pwd_mode;
  assign lock_set  = accept && (op == OP_LOCK_SET);
  assign rd_pwd    = accept && (op == OP_PWD_RD);
  assign rd_stat   = cmd_valid_i && (op == OP_STAT_RD);

  pwd_store #(.PWD_W(PWD_W), .MODE_BIT(MODE_BIT)) u_store (
    .clk_i      (clk_i),
    .pgm_i      (pgm_en),
    .mode_pgm_i (mode_en),
    .data_i     (cmd_data_i),
    .pwd_o      (pwd),
    .pwd_mode_o (pwd_mode)
  );

  pwd_match #(.PWD_W(PWD_W), .CHUNK_W(CHUNK_W)) u_match (
    .a_i     (pwd),
    .b_i     (cmd_data_i),
    .match_o (match)
  );

  pwd_delay_timer #(.SHORT_CYCLES(UNLOCK_CYCLES), .LONG_CYCLES(PENALTY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (unlock_go),
    .long_i  (!match),
    .busy_o  (busy),
    .done_o  (done)
  );

  // reset value of the lock flag follows the non-volatile mode bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= pwd_mode;
      p_err_q <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      if (unlock_go) begin
        p_err_q <= !match;
        good_q  <= match;
      end
      if (done && good_q) lock_q <= 1'b0;
      else if (lock_set)  lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_pwd || rd_stat;
      if (rd_stat)     rd_data_q <= {{(PWD_W-2){1'b0}}, p_err_q, busy};
      else if (rd_pwd) rd_data_q <= pwd_mode ? '0 : pwd;
    end
  end

  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign lock_o       = lock_q;
  assign prot_wr_en_o = ~lock_q;
  assign wip_o        = busy;
  assign p_err_o      = p_err_q;
endmodule

// File: rtl/pwd_lock_ctrl_chk.sv
module pwd_lock_ctrl_chk
  import pwd_lock_pkg::*;
#(
  parameter int unsigned PWD_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             rd_valid_o,
  input logic [PWD_W-1:0] rd_data_o,
  input logic             lock_o,
  input logic             wip_o,
  input logic             p_err_o,
  input logic             pwd_mode_i
);
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwd_mode_i |=> pwd_mode_i); // R3

  AST_SEALED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwd_mode_i && cmd_valid_i && !wip_o && cmd_op_i == OP_PWD_RD)
      |=> (rd_valid_o && rd_data_o == '0)); // R4

  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(cmd_valid_i && !wip_o && cmd_op_i == OP_LOCK_SET)); // R5

  AST_LOCK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> ($fell(wip_o) && !p_err_o)); // R6

  AST_ERR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p_err_o) |-> wip_o); // R7

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cmd_valid_i && cmd_op_i == OP_UNLOCK && pwd_mode_i)); // R8

  AST_STAT_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_STAT_RD)
      |=> (rd_valid_o && rd_data_o == {{(PWD_W-2){1'b0}}, $past(p_err_o), $past(wip_o)})); // R9

  AST_PREMODE_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwd_mode_i && cmd_valid_i && cmd_op_i == OP_UNLOCK && !wip_o) |=> !wip_o); // R10
endmodule

bind pwd_lock_ctrl pwd_lock_ctrl_chk #(.PWD_W(PWD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .lock_o      (lock_o),
  .wip_o       (wip_o),
  .p_err_o     (p_err_o),
  .pwd_mode_i  (pwd_mode)
);

// File: tb/pwd_lock_ctrl_test.sv
`timescale 1ns/1ps
module pwd_lock_ctrl_test;
  localparam int unsigned UNL = 4;
  localparam int unsigned PEN = 40;

  localparam logic [2:0] C_PGM  = 3'd1;
  localparam logic [2:0] C_RD   = 3'd2;
  localparam logic [2:0] C_MODE = 3'd3;
  localparam logic [2:0] C_UNL  = 3'd4;
  localparam logic [2:0] C_LOCK = 3'd5;
  localparam logic [2:0] C_STAT = 3'd6;

  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] PW   = 64'h00F0_FFFF_1234_FF00;

  // {op, operand, check, expected rd_data}
  localparam int NV = 10;
  localparam logic [131:0] VEC [NV] = '{
    {C_RD,   64'h0,                   1'b1, ONES},
    {C_PGM,  64'hF0F0_FFFF_FFFF_FF00, 1'b0, 64'h0},
    {C_RD,   64'h0,                   1'b1, 64'hF0F0_FFFF_FFFF_FF00},
    {C_PGM,  64'h0FFF_FFFF_1234_FFFF, 1'b0, 64'h0},
    {C_RD,   64'h0,                   1'b1, PW},
    {C_PGM,  ONES,                    1'b0, 64'h0},
    {C_RD,   64'h0,                   1'b1, PW},
    {C_STAT, 64'h0,                   1'b1, 64'h0},
    {C_UNL,  64'h1234,                1'b0, 64'h0},
    {C_STAT, 64'h0,                   1'b1, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_data = '0;
  logic        rd_valid, lock, prot_en, wip, p_err;
  logic [63:0] rd_data;

  int total = 0;
  int bad = 0;
  int cyc;

  always #5 clk = ~clk;

  pwd_lock_ctrl #(.UNLOCK_CYCLES(UNL), .PENALTY_CYCLES(PEN)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_data_i   (cmd_data),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data),
    .lock_o       (lock),
    .prot_wr_en_o (prot_en),
    .wip_o        (wip),
    .p_err_o      (p_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the falling edge after the accepting edge
  task automatic issue(input logic [2:0] op, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (wip && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state before mode
    chk("R5 reset lock", {63'b0, lock}, 64'h0);
    chk("R5 reset en",   {63'b0, prot_en}, 64'h1);
    chk("R9 reset wip/err", {62'b0, p_err, wip}, 64'h0);
    chk("R1 reset rd_valid", {63'b0, rd_valid}, 64'h0);

    // table: R1 factory value, R2 AND-only programming, R9 status, R10 early unlock
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][131:129], VEC[i][128:65]);
      if (VEC[i][64]) begin
        chk($sformatf("R1/R2/R9 vec%0d valid", i), {63'b0, rd_valid}, 64'h1);
        chk($sformatf("R1/R2/R9 vec%0d data", i), rd_data, VEC[i][63:0]);
      end
    end
    chk("R10 early unlock wip/err", {62'b0, p_err, wip}, 64'h0);
    chk("R10 early unlock lock", {63'b0, lock}, 64'h0);

    // R5 ordinary lock before mode
    issue(C_LOCK, '0);
    chk("R5 lock set", {62'b0, lock, prot_en}, 64'h2);
    issue(C_UNL, PW);
    chk("R10 unlock ignored", {62'b0, lock, wip}, 64'h2);
    do_reset();
    chk("R5 pre-mode reset opens", {63'b0, lock}, 64'h0);

    // R3 mode bit: a 1 in bit 2 does nothing
    issue(C_MODE, ONES);
    issue(C_RD, '0);
    chk("R3 bit2=1 no mode", rd_data, PW);
    issue(C_MODE, 64'hFFFF_FFFF_FFFF_FFFB);
    issue(C_RD, '0);
    chk("R4 sealed read valid", {63'b0, rd_valid}, 64'h1);
    chk("R4 sealed read", rd_data, 64'h0);
    issue(C_PGM, 64'h0);            // must be ignored
    issue(C_MODE, ONES);            // cannot revert

    do_reset();
    chk("R5 mode reset locks", {62'b0, lock, prot_en}, 64'h2);
    issue(C_RD, '0);
    chk("R3 mode survives reset", rd_data, 64'h0);

    // R7 wrong password: full penalty
    issue(C_UNL, PW ^ 64'h1);
    chk("R7 err set", {63'b0, p_err}, 64'h1);
    busy_len(cyc);
    chk("R7 penalty length", 64'(cyc), 64'(PEN));
    chk("R7 lock kept", {63'b0, lock}, 64'h1);
    chk("R7 err sticky", {63'b0, p_err}, 64'h1);

    // R8 correct password during penalty is dropped
    issue(C_UNL, PW ^ 64'h8000_0000_0000_0000);
    issue(C_UNL, PW);
    issue(C_STAT, '0);
    chk("R9 status while busy", rd_data, 64'h3);
    busy_len(cyc);
    chk("R8 ignored unlock lock", {63'b0, lock}, 64'h1);
    chk("R8 ignored unlock err", {63'b0, p_err}, 64'h1);

    // R6 correct unlock (also shows the ignored program kept PW, R4)
    issue(C_UNL, PW);
    chk("R6 err cleared", {63'b0, p_err}, 64'h0);
    chk("R6 still locked while busy", {63'b0, lock}, 64'h1);
    busy_len(cyc);
    chk("R6 unlock length", 64'(cyc), 64'(UNL));
    chk("R6 opened", {62'b0, lock, prot_en}, 64'h1);
    issue(C_STAT, '0);
    chk("R9 status idle", rd_data, 64'h0);

    // R5 relock and again reset closes
    issue(C_LOCK, '0);
    chk("R5 relock", {63'b0, lock}, 64'h1);
    do_reset();
    chk("R5 reset relocks", {63'b0, lock}, 64'h1);
    chk("R7 reset clears err", {63'b0, p_err}, 64'h0);
    issue(C_UNL, PW);
    busy_len(cyc);
    chk("R4 password intact after reset", {63'b0, lock}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule